// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block is a leaf of a clock generator. It turns a parent clock into a one-cycle enable pulse every N parent cycles. N comes from a programmed divisor field, and a separate enable bit gates the pulse train. The field is either 5 bits wide or 6 bits wide. In the 6-bit variant, the top bit of the field selects a fixed divide-by-64 prescale. A field value of zero always stands for the largest ratio.

Software writes the divisor through a one-cycle write strobe and then polls the status word. Two busy bits stay set while the new ratio is waiting for the end of the current output period and for one cycle after that. Two kinds of write are dropped and set a sticky error flag:
- a write made while busy;
- a write whose value does not fit the field.

Top module: `clkdiv_top`

## Requirements
- R1: In 5-bit mode (FIELD_W=5) a written value V in 1..31 gives a tick period of V parent cycles. In 6-bit mode a value V in 1..31 (bit 5 clear) gives V.
- R2: A field value of 0 selects the largest ratio: 32 in 5-bit mode and 64 in 6-bit mode.
- R3: In 6-bit mode, bit 5 of the field set makes the ratio 64 times bits 4:0. If bits 4:0 are 0, the ratio is 64.
- R4: While the enable bit is 0, tick_o stays low and the period counter is held at zero. After the enable bit is set, the first tick comes on the Nth parent cycle.
- R5: While enabled with ratio N, tick_o is high for exactly one parent cycle every N cycles. For N=1 it is high in every cycle.
- R6: After an accepted divisor write, status_o reads 0x18 (bits 3 and 4 set). It stays at that value until the cycle after the period boundary where the new ratio is loaded, and then reads 0x00. No other status bit is ever set.
- R7: A new ratio takes effect only at the end of the period in progress, so the period that spans the write keeps the old length.
- R8: A write whose value has any bit set above the field width is ignored. It sets err_o, and the ratio in use is unchanged.
- R9: A write made while busy is ignored and sets err_o. err_o stays set until reset.
- R10: After reset the ratio is the largest one (field value 0), the output is disabled, status_o is 0 and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | Divisor write strobe |
| div_data_i | input | DATA_W | Divisor value written |
| gate_wr_i | input | 1 | Enable write strobe |
| gate_val_i | input | 1 | Enable value written |
| tick_o | output | 1 | Divided clock-enable pulse |
| status_o | output | 8 | Status word, busy on bits 3 and 4 |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
The hardest case to reach is a divisor write that lands in the middle of a running period, followed by a second write while the first is still pending. The bench waits for an output tick and issues the first write at that exact sampling point. It then fires the second write a few cycles later. Sampling every cycle afterwards shows three things: the old period completes at full length, busy falls exactly one cycle after the boundary, and the rejected ratio never appears.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int STATUS_W = 8;
    localparam logic [STATUS_W-1:0] BUSY_MASK = 8'h18;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_PEND   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 6
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic               legal_i_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam logic [RATIO_W-1:0] FULL = RATIO_W'(1) << FIELD_W;

    logic [FIELD_W-1:0] field;
    logic [RATIO_W-1:0] raw;

    assign field     = data_i[FIELD_W-1:0];
    assign legal_i_o = (data_i >> FIELD_W) == '0;

    generate
        if (FIELD_W == 6) begin : g_prescale
            always_comb begin
                if (field[5]) raw = RATIO_W'({field[4:0], 6'b0});
                else          raw = RATIO_W'(field[4:0]);
            end
        end else begin : g_plain
            assign raw = RATIO_W'(field);
        end
    endgenerate

    assign ratio_o = (raw == '0) ? FULL : raw;
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
    parameter int RATIO_W = 6,
    parameter logic [RATIO_W-1:0] RESET_RATIO = '1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic               legal_i,
    input  logic [RATIO_W-1:0] new_ratio_i,
    input  logic               gate_wr_i,
    input  logic               gate_val_i,
    input  logic               boundary_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               en_o,
    output logic               busy_o,
    output logic               err_o
);
    import clkdiv_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] pend;
        logic               en;
        logic               err;
    } state_t;

    state_t st_d, st_q;
    logic   busy;

    always_comb begin
        st_d = st_q;
        busy = (st_q.phase != PH_IDLE);
        case (st_q.phase)
            PH_PEND: begin
                if (boundary_i || !st_q.en) begin
                    st_d.ratio = st_q.pend;
                    st_d.phase = PH_SETTLE;
                end
            end
            PH_SETTLE: st_d.phase = PH_IDLE;
            default:   st_d.phase = st_q.phase;
        endcase
        if (wr_i) begin
            if (busy || !legal_i) begin
                st_d.err = 1'b1;
            end else begin
                st_d.pend  = new_ratio_i;
                st_d.phase = PH_PEND;
            end
        end
        if (gate_wr_i) st_d.en = gate_val_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.ratio <= RESET_RATIO;
            st_q.pend  <= RESET_RATIO;
            st_q.en    <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_o = st_q.ratio;
    assign en_o    = st_q.en;
    assign busy_o  = busy;
    assign err_o   = st_q.err;
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
    parameter int RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    logic [RATIO_W-1:0] cnt_d, cnt_q;
    logic               last;

    always_comb begin
        last = (cnt_q == ratio_i - RATIO_W'(1));
        if (!en_i)     cnt_d = '0;
        else if (last) cnt_d = '0;
        else           cnt_d = cnt_q + RATIO_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = en_i && last;
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top #(
    parameter int DATA_W  = 8,
    parameter int FIELD_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              div_wr_i,
    input  logic [DATA_W-1:0] div_data_i,
    input  logic              gate_wr_i,
    input  logic              gate_val_i,
    output logic              tick_o,
    output logic [7:0]        status_o,
    output logic              err_o
);
    import clkdiv_pkg::*;

    localparam int RATIO_W = (FIELD_W == 6) ? FIELD_W + 5 : FIELD_W + 1;
    localparam logic [RATIO_W-1:0] FULL = RATIO_W'(1) << FIELD_W;

    logic               dec_legal;
    logic [RATIO_W-1:0] dec_ratio;
    logic [RATIO_W-1:0] ctl_ratio;
    logic               ctl_en;
    logic               ctl_busy;

    clkdiv_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_dec (
        .data_i    (div_data_i),
        .legal_i_o (dec_legal),
        .ratio_o   (dec_ratio)
    );

    clkdiv_ctrl #(.RATIO_W(RATIO_W), .RESET_RATIO(FULL)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (div_wr_i),
        .legal_i     (dec_legal),
        .new_ratio_i (dec_ratio),
        .gate_wr_i   (gate_wr_i),
        .gate_val_i  (gate_val_i),
        .boundary_i  (tick_o),
        .ratio_o     (ctl_ratio),
        .en_o        (ctl_en),
        .busy_o      (ctl_busy),
        .err_o       (err_o)
    );

    clkdiv_count #(.RATIO_W(RATIO_W)) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (ctl_en),
        .ratio_i (ctl_ratio),
        .tick_o  (tick_o)
    );

    assign status_o = ctl_busy ? BUSY_MASK : '0;
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int RATIO_W = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               div_wr_i,
    input logic               legal_i,
    input logic               busy_i,
    input logic               en_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               tick_i,
    input logic               err_i
);
    // R9
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> err_i);

    // R9
    busy_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_wr_i && busy_i) |=> err_i);

    // R8
    illegal_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_wr_i && !legal_i) |=> err_i);

    // R6
    accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_wr_i && !busy_i && legal_i) |=> busy_i);

    // R7
    ratio_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ratio_i) |-> ($past(tick_i) || !$past(en_i)));

    // R4
    tick_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |-> en_i);

    // R5
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && ratio_i != RATIO_W'(1) && !busy_i) |=> !tick_i);
endmodule

bind clkdiv_top clkdiv_chk #(.RATIO_W(RATIO_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_wr_i (div_wr_i),
    .legal_i  (dec_legal),
    .busy_i   (ctl_busy),
    .en_i     (ctl_en),
    .ratio_i  (ctl_ratio),
    .tick_i   (tick_o),
    .err_i    (err_o)
);

// File: tb/tb_clkdiv_top.sv
`timescale 1ns/1ps
module tb_clkdiv_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // wide (6-bit) instance signals
    logic       w_wr = 0, w_gwr = 0, w_gval = 0;
    logic [7:0] w_data = 0;
    logic       w_tick, w_err;
    logic [7:0] w_stat;
    // narrow (5-bit) instance signals
    logic       n_wr = 0, n_gwr = 0, n_gval = 0;
    logic [7:0] n_data = 0;
    logic       n_tick, n_err;
    logic [7:0] n_stat;

    int checks = 0;
    int errors = 0;

    clkdiv_top #(.DATA_W(8), .FIELD_W(6)) dut (
        .clk_i(clk), .rst_ni(rst_n), .div_wr_i(w_wr), .div_data_i(w_data),
        .gate_wr_i(w_gwr), .gate_val_i(w_gval),
        .tick_o(w_tick), .status_o(w_stat), .err_o(w_err));

    clkdiv_top #(.DATA_W(8), .FIELD_W(5)) dut_n (
        .clk_i(clk), .rst_ni(rst_n), .div_wr_i(n_wr), .div_data_i(n_data),
        .gate_wr_i(n_gwr), .gate_val_i(n_gval),
        .tick_o(n_tick), .status_o(n_stat), .err_o(n_err));

    // {data, expected ratio} for the 6-bit instance
    localparam logic [18:0] VEC [0:8] = '{
        {8'h05, 11'd5},    // R1
        {8'h00, 11'd64},   // R2
        {8'h01, 11'd1},    // R1 / R5
        {8'h1F, 11'd31},   // R1
        {8'h20, 11'd64},   // R3 zero low bits
        {8'h21, 11'd64},   // R3
        {8'h23, 11'd192},  // R3
        {8'h3F, 11'd1984}, // R3
        {8'h09, 11'd9}     // R1
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic tick_of(input bit wide);
        return wide ? w_tick : n_tick;
    endfunction

    task automatic wr_div(input bit wide, input logic [7:0] v);
        @(negedge clk);
        if (wide) begin w_wr = 1; w_data = v; end
        else      begin n_wr = 1; n_data = v; end
        @(negedge clk);
        w_wr = 0; n_wr = 0;
    endtask

    task automatic set_gate(input bit wide, input logic v);
        @(negedge clk);
        if (wide) begin w_gwr = 1; w_gval = v; end
        else      begin n_gwr = 1; n_gval = v; end
        @(negedge clk);
        w_gwr = 0; n_gwr = 0;
    endtask

    task automatic wait_idle(input bit wide);
        for (int i = 0; i < 5000; i++) begin
            if ((wide ? w_stat : n_stat) == 8'h00) break;
            @(negedge clk);
        end
    endtask

    // returns cycles between two successive ticks
    task automatic measure(input bit wide, output int period);
        period = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tick_of(wide)) break;
        end
        for (int i = 1; i < 5000; i++) begin
            @(negedge clk);
            if (tick_of(wide)) begin period = i; break; end
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int p;
        int seen;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 wide status", w_stat, 0);
        check("R10 wide err", w_err, 0);
        check("R10 wide tick", w_tick, 0);
        check("R10 narrow status", n_stat, 0);
        check("R10 narrow err", n_err, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R4 disabled no tick", w_tick | n_tick, 0);

        // R10 / R2: reset ratio is the largest
        set_gate(1'b0, 1'b1);
        measure(1'b0, p);
        check("R10 R2 narrow reset ratio", p, 32);
        set_gate(1'b1, 1'b1);
        measure(1'b1, p);
        check("R10 R2 wide reset ratio", p, 64);

        // table of decode vectors on the 6-bit instance
        for (int k = 0; k < 9; k++) begin
            wr_div(1'b1, VEC[k][18:11]);
            wait_idle(1'b1);
            measure(1'b1, p);
            check("R1/R2/R3 decode period", p, int'(VEC[k][10:0]));
        end

        // R1 narrow mode
        wr_div(1'b0, 8'h07);
        wait_idle(1'b0);
        measure(1'b0, p);
        check("R1 narrow period", p, 7);
        // R8 illegal value on the narrow instance
        wr_div(1'b0, 8'h20);
        @(negedge clk);
        check("R8 illegal sets err", n_err, 1);
        check("R8 illegal not busy", n_stat, 0);
        measure(1'b0, p);
        check("R8 ratio unchanged", p, 7);

        // R4 disable then re-enable, wide ratio 9
        set_gate(1'b1, 1'b0);
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            seen += w_tick;
        end
        check("R4 no tick while disabled", seen, 0);
        @(negedge clk);
        w_gwr = 1; w_gval = 1;
        p = -1;
        for (int i = 1; i < 100; i++) begin
            @(negedge clk);
            w_gwr = 0;
            if (w_tick) begin p = i; break; end
        end
        check("R4 first tick after enable", p, 9);

        // R6 R7 R9: write at a boundary, second write while busy
        check("R9 err clear before", w_err, 0);
        for (int i = 0; i < 100; i++) begin
            if (w_tick) break;
            @(negedge clk);
        end
        w_wr = 1; w_data = 8'h05;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            w_wr = 0;
            check("R6 status during update", w_stat, (i <= 10) ? 8'h18 : 8'h00);
            check("R7 R5 tick position", w_tick, (i == 9 || i == 14 || i == 19) ? 1 : 0);
            if (i == 3) begin w_wr = 1; w_data = 8'h01; end
        end
        check("R9 busy write sets err", w_err, 1);
        measure(1'b1, p);
        check("R9 rejected ratio absent", p, 5);
        check("R9 err sticky", w_err, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule